// File: doc/BRIEF.md
# Cascadable Decimal Up/Down Counter Digit

This block is one decimal digit of a counter. It holds a 4-bit BCD value that steps up or down by one on each rising clock edge while its active-low enable is low. A direction input picks the step. The value wraps from 9 to 0 when counting up and from 0 to 9 when counting down. An active-high master reset clears the digit at once and overrides every other input. An active-high load copies a 4-bit input word into the digit while it is held high, without waiting for a clock.

An active-low terminal-count output marks the last state in the current direction: 9 going up, 0 going down. It is a combinational function of the visible count, the direction and the enable. It is asserted only while the enable is low. To build a multi-digit counter, the terminal-count output of each digit feeds the enable of the next digit up, and all digits share one clock. The whole chain then advances in one synchronous step.

The up-direction terminal decode looks only at bits 0 and 3. Parameter `FULL_UP_DECODE` selects a full compare against 9 instead. The default keeps the two-bit decode.

Top module: `bcd_updown_digit`

## Requirements
- R1: A high on `rst` forces `count` to 0 at once, without a clock edge. This holds even while `load` is high.
- R2: While `load` is high and `rst` is low, `count` equals `load_val` at once. This does not depend on `clk`, `cnt_en_n` or `dir_up`. Load takes priority over counting.
- R3: With `rst` and `load` low and `cnt_en_n` low, each rising `clk` edge moves the count by one. The count goes up when `dir_up` is 1 and down when `dir_up` is 0.
- R4: Counting up from 9 gives 0. Counting down from 0 gives 9.
- R5: With `cnt_en_n` high and `rst` and `load` low, the count keeps its value across clock edges.
- R6: `term_n` is 0 exactly when `cnt_en_n` is 0 and one of two conditions holds: `dir_up` is 1 with `count[0]` and `count[3]` both 1, or `dir_up` is 0 with `count` equal to 0. It follows changes of `dir_up` and `cnt_en_n` without a clock edge.
- R7: With the default decode, counting up from a loaded code with bits 0 and 3 both set (11, 13, 15) gives 0. Counting up from 10, 12 or 14 gives that value plus one. Counting down from any code from 10 to 15 gives that value minus one.
- R8: A value loaded while `load` is held high across a rising clock edge stays in the count after `load` falls. Counting resumes from that value.
- R9: Three digits chained with `term_n` into the next digit's `cnt_en_n` count from 000 through 999 and wrap to 000 going up. Going down from 000 they reach 999 and then count back down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst | input | 1 | Asynchronous master clear, active high |
| load | input | 1 | Asynchronous level load, active high |
| load_val | input | 4 | Value copied into the digit while `load` is high |
| cnt_en_n | input | 1 | Count enable, active low; also gates `term_n` |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| count | output | 4 | Current BCD digit |
| term_n | output | 1 | Terminal count, active low |

## Verification
A vector table runs the digit through loads, both count directions, holds, wraps and non-BCD entry codes. The up wrap and down wrap are told apart by their opposite end states. The non-BCD rows separate the two-bit up decode from a full compare: 13 must go to 0, while 12 must go to 13. Directed cases change `dir_up`, `cnt_en_n`, `rst` and `load` between clock edges. These cases show that reset, load and the terminal output take effect without a clock. A three-digit chain, counted through a full cycle in each direction, checks that the enable gating of the terminal output carries correctly at 9 and at 0.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   localparam int unsigned BCD_W   = 4;
   localparam int unsigned BCD_TOP = 9;
   typedef logic [BCD_W-1:0] digit_t;
endpackage

// File: rtl/bcd_edge_decode.sv
module bcd_edge_decode #(
   parameter int unsigned DIGIT_W        = 4,
   parameter int unsigned DIGIT_MAX      = 9,
   parameter bit          FULL_UP_DECODE = 1'b0
) (
   input  logic [DIGIT_W-1:0] q,
   output logic               at_top,
   output logic               at_zero
);
   localparam logic [DIGIT_W-1:0] MAXV = DIGIT_W'(DIGIT_MAX);

   generate
      if (FULL_UP_DECODE) begin : g_full
         assign at_top = (q == MAXV);
      end else begin : g_sparse
         assign at_top = q[0] & q[DIGIT_W-1];
      end
   endgenerate

   assign at_zero = (q == '0);
endmodule

// File: rtl/bcd_step.sv
module bcd_step #(
   parameter int unsigned DIGIT_W   = 4,
   parameter int unsigned DIGIT_MAX = 9
) (
   input  logic [DIGIT_W-1:0] q,
   input  logic               up,
   input  logic               at_top,
   input  logic               at_zero,
   output logic [DIGIT_W-1:0] q_next
);
   localparam logic [DIGIT_W-1:0] MAXV = DIGIT_W'(DIGIT_MAX);
   localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

   always_comb begin
      if (up) q_next = at_top  ? '0   : q + ONE;
      else    q_next = at_zero ? MAXV : q - ONE;
   end

   // R4
   always_comb begin
      if (q <= MAXV) begin
         step_in_range_chk: assert (q_next <= MAXV);
      end
   end
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit #(
   parameter int unsigned DIGIT_W        = bcd_pkg::BCD_W,
   parameter int unsigned DIGIT_MAX      = bcd_pkg::BCD_TOP,
   parameter bit          FULL_UP_DECODE = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [DIGIT_W-1:0] load_val,
   input  logic               cnt_en_n,
   input  logic               dir_up,
   output logic [DIGIT_W-1:0] count,
   output logic               term_n
);
   localparam logic [DIGIT_W-1:0] MAXV = DIGIT_W'(DIGIT_MAX);
   localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

   generate
      if (DIGIT_W != bcd_pkg::BCD_W) begin : g_bad_width
         $error("bcd_updown_digit: DIGIT_W must equal a BCD digit width");
      end
      if (DIGIT_MAX >= (1 << DIGIT_W)) begin : g_bad_max
         $error("bcd_updown_digit: DIGIT_MAX does not fit in DIGIT_W");
      end
   endgenerate

   logic [DIGIT_W-1:0] cnt_q;
   logic [DIGIT_W-1:0] cnt_d;
   logic               at_top;
   logic               at_zero;
   logic               past_ok;

   // visible value: reset beats load, load beats the stored digit
   always_comb begin
      if (rst)       count = '0;
      else if (load) count = load_val;
      else           count = cnt_q;
   end

   bcd_edge_decode #(
      .DIGIT_W       (DIGIT_W),
      .DIGIT_MAX     (DIGIT_MAX),
      .FULL_UP_DECODE(FULL_UP_DECODE)
   ) i_decode (
      .q      (count),
      .at_top (at_top),
      .at_zero(at_zero)
   );

   bcd_step #(
      .DIGIT_W  (DIGIT_W),
      .DIGIT_MAX(DIGIT_MAX)
   ) i_step (
      .q      (count),
      .up     (dir_up),
      .at_top (at_top),
      .at_zero(at_zero),
      .q_next (cnt_d)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst)            cnt_q <= '0;
      else if (load)      cnt_q <= load_val;
      else if (!cnt_en_n) cnt_q <= cnt_d;
   end

   assign term_n = ~(~cnt_en_n & (dir_up ? at_top : at_zero));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   // R2
   load_chk: assert property (@(posedge clk) disable iff (rst)
      past_ok && $past(load) |-> cnt_q == $past(load_val));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      past_ok && $past(!load && cnt_en_n) |-> cnt_q == $past(cnt_q));

   // R3
   step_up_chk: assert property (@(posedge clk) disable iff (rst)
      past_ok && $past(!load && !cnt_en_n && dir_up && cnt_q < MAXV)
      |-> cnt_q == $past(cnt_q) + ONE);

   // R4
   wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
      past_ok && $past(!load && !cnt_en_n && dir_up && cnt_q == MAXV)
      |-> cnt_q == '0);

   // R4
   wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
      past_ok && $past(!load && !cnt_en_n && !dir_up && cnt_q == '0)
      |-> cnt_q == MAXV);

   // R6
   tc_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !term_n |-> !cnt_en_n);
endmodule

// File: tb/test_bcd_updown_digit.sv
module test_bcd_updown_digit;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 20;

   // packing: {load, load_val[3:0], cnt_en_n, dir_up, exp_count[3:0], exp_term_n}
   localparam logic [11:0] VEC [NVEC] = '{
      {1'b1, 4'd7,  1'b1, 1'b1, 4'd7,  1'b1},
      {1'b0, 4'd0,  1'b0, 1'b1, 4'd8,  1'b1},
      {1'b0, 4'd0,  1'b0, 1'b1, 4'd9,  1'b0},
      {1'b0, 4'd0,  1'b0, 1'b1, 4'd0,  1'b1},
      {1'b0, 4'd0,  1'b0, 1'b0, 4'd9,  1'b1},
      {1'b0, 4'd0,  1'b0, 1'b0, 4'd8,  1'b1},
      {1'b0, 4'd0,  1'b1, 1'b0, 4'd8,  1'b1},
      {1'b1, 4'd2,  1'b0, 1'b0, 4'd2,  1'b1},
      {1'b0, 4'd0,  1'b0, 1'b0, 4'd1,  1'b1},
      {1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
      {1'b0, 4'd0,  1'b1, 1'b0, 4'd0,  1'b1},
      {1'b1, 4'd12, 1'b1, 1'b1, 4'd12, 1'b1},
      {1'b0, 4'd0,  1'b0, 1'b1, 4'd13, 1'b0},
      {1'b0, 4'd0,  1'b0, 1'b1, 4'd0,  1'b1},
      {1'b1, 4'd15, 1'b1, 1'b0, 4'd15, 1'b1},
      {1'b0, 4'd0,  1'b0, 1'b0, 4'd14, 1'b1},
      {1'b1, 4'd10, 1'b1, 1'b1, 4'd10, 1'b1},
      {1'b0, 4'd0,  1'b0, 1'b1, 4'd11, 1'b0},
      {1'b0, 4'd0,  1'b0, 1'b1, 4'd0,  1'b1},
      {1'b1, 4'd9,  1'b0, 1'b0, 4'd9,  1'b1}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load = 1'b0;
   logic [3:0] load_val = 4'd0;
   logic       cnt_en_n = 1'b1;
   logic       dir_up = 1'b1;
   logic [3:0] count;
   logic       term_n;

   logic       c_rst = 1'b1;
   logic       c_en_n = 1'b1;
   logic       c_up = 1'b1;
   logic [3:0] d0, d1, d2;
   logic       t0, t1, t2;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_updown_digit i_bcd_updown_digit (
      .clk(clk), .rst(rst), .load(load), .load_val(load_val),
      .cnt_en_n(cnt_en_n), .dir_up(dir_up), .count(count), .term_n(term_n));

   bcd_updown_digit i_dig0 (
      .clk(clk), .rst(c_rst), .load(1'b0), .load_val(4'd0),
      .cnt_en_n(c_en_n), .dir_up(c_up), .count(d0), .term_n(t0));
   bcd_updown_digit i_dig1 (
      .clk(clk), .rst(c_rst), .load(1'b0), .load_val(4'd0),
      .cnt_en_n(t0), .dir_up(c_up), .count(d1), .term_n(t1));
   bcd_updown_digit i_dig2 (
      .clk(clk), .rst(c_rst), .load(1'b0), .load_val(4'd0),
      .cnt_en_n(t1), .dir_up(c_up), .count(d2), .term_n(t2));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int chain_val();
      return int'(d2) * 100 + int'(d1) * 10 + int'(d0);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1 count under reset", int'(count), 0);
      check("R6 term_n idle", int'(term_n), 1);
      rst = 1'b0;
      @(negedge clk);
      check("R5 hold after reset", int'(count), 0);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         {load, load_val, cnt_en_n, dir_up} = VEC[i][11:5];
         @(posedge clk);
         #1;
         check($sformatf("R3/R4/R7 vec %0d count", i), int'(count), int'(VEC[i][4:1]));
         check($sformatf("R6 vec %0d term_n", i), int'(term_n), int'(VEC[i][0]));
      end

      // R1 reset beats load, no clock needed
      @(negedge clk);
      load = 1'b1; load_val = 4'd6; cnt_en_n = 1'b1;
      #1 rst = 1'b1;
      #1 check("R1 reset over load", int'(count), 0);
      rst = 1'b0;
      #1 check("R2 async load visible", int'(count), 6);
      @(negedge clk);
      load = 1'b0;
      @(negedge clk);
      check("R8 loaded value retained", int'(count), 6);
      cnt_en_n = 1'b0; dir_up = 1'b1;
      @(negedge clk);
      check("R8 count resumes", int'(count), 7);
      cnt_en_n = 1'b1;

      // R6 combinational terminal count at 9
      load = 1'b1; load_val = 4'd9;
      @(negedge clk);
      load = 1'b0;
      #1 check("R6 enable high masks", int'(term_n), 1);
      cnt_en_n = 1'b0; dir_up = 1'b1;
      #1 check("R6 up at 9", int'(term_n), 0);
      dir_up = 1'b0;
      #1 check("R6 down at 9", int'(term_n), 1);
      cnt_en_n = 1'b1;
      #1 check("R5 no change between edges", int'(count), 9);

      // R1 asynchronous clear mid-cycle
      @(negedge clk);
      #1 rst = 1'b1;
      #1 check("R1 async clear", int'(count), 0);
      rst = 1'b0;

      // R9 three-digit chain
      @(negedge clk);
      c_rst = 1'b0; c_en_n = 1'b0; c_up = 1'b1;
      for (int i = 1; i <= 1000; i++) begin
         @(posedge clk);
         #1;
         check("R9 chain up", chain_val(), i % 1000);
         if (i == 999) check("R9 chain top term_n", int'(t2), 0);
      end
      @(negedge clk);
      c_up = 1'b0;
      for (int i = 1; i <= 1000; i++) begin
         @(posedge clk);
         #1;
         check("R9 chain down", chain_val(), (1000 - i) % 1000);
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule